// File: doc/BRIEF.md
# Serial Block Store Controller

This block is a bit-serial slave in front of a small block-organised store. A host moves one bit into it per input strobe and pulls one bit out of it per output strobe. Every transaction opens with a 2-bit command and a 6-bit block number, both sent most-significant bit first. A write then carries a 64-bit block and a closing zero bit. A read takes the closing zero bit at once, answers the first four output strobes with zeros, and then streams the 64-bit block.

The store holds 64 blocks of 8 bytes in a synchronous RAM with one lane per byte. Byte offset 0 of a block is the first byte on the wire in both directions. A block is committed only once its stop bit has been accepted. A wrong command code or a non-zero stop bit raises a one-cycle error pulse and puts the controller back in the idle state.

Top module: `serial_block_store`

## Requirements
- R1: After reset `ready` is 1 and `data_avail`, `bit_out` and `err` are 0.
- R2: The first two input bits form the command, MSB first. 2'b11 means read and 2'b10 means write. For 2'b00 or 2'b01, `err` is 1 in the cycle after the second bit's strobe and `ready` is 1 in that same cycle.
- R3: The next six input bits, MSB first, form the block number A, which selects store bytes 8*A through 8*A+7. Each of the 64 blocks holds its own contents.
- R4: A write takes exactly 64 data bits, MSB first. The first byte received is stored at block offset 0 and the last byte at offset 7.
- R5: After the 64 write bits, a 0 stop bit commits the block and returns the controller to idle. A 1 stop bit pulses `err`, returns to idle and leaves the block unchanged.
- R6: A read expects a 0 stop bit right after the address. A 1 instead pulses `err`, returns to idle and produces no data.
- R7: After the read stop bit, the first four output strobes each yield 0 and `data_avail` stays 0 until the fourth one.
- R8: The next 64 output strobes yield the block MSB first, starting with offset 0. `data_avail` is 1 during this phase and only during it.
- R9: The output strobe after the 64th data bit yields 0, drops `data_avail` and leaves `ready` at 1.
- R10: An output strobe in any state other than read transmit yields 0 and does not disturb an input transfer that is in progress.
- R11: Input strobes are ignored while dummy bits or read data are being sent.
- R12: `bit_out` is a registered output. It takes its new value in the cycle after an output strobe and holds it until the next one.
- R13: `err` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | Accept `bit_in` this cycle |
| bit_in | input | 1 | Serial data into the controller |
| out_stb | input | 1 | Request one output bit this cycle |
| bit_out | output | 1 | Serial data out, registered |
| data_avail | output | 1 | High while read data is being sent |
| ready | output | 1 | Idle and waiting for a command |
| err | output | 1 | One-cycle pulse on a bad command or stop bit |

## Verification
The input strobe and the output strobe can arrive in the same cycle. Depending on the phase, one of them is meaningful and the other must have no effect.

The bench provokes this in two ways. It raises the output strobe in the middle of a write's data bits, where the strobe must return 0 and the block must still read back intact. It also holds the input strobe high, with a data value of 1, alongside every output strobe of a read, where the dummy zeros, the 64 data bits and the return to idle must all come out exactly as in a clean read. Expected blocks come from an odd-multiplier formula of the block number, so any aliasing between blocks or any slip in bit order shows up as a mismatched word.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   typedef enum logic [2:0] {
      ST_CMD   = 3'd0,
      ST_ADDR  = 3'd1,
      ST_WDATA = 3'd2,
      ST_WSTOP = 3'd3,
      ST_RSTOP = 3'd4,
      ST_DUMMY = 3'd5,
      ST_TXD   = 3'd6
   } sbs_state_e;

   localparam int SBS_BYTE_W = 8;
endpackage

// File: rtl/sbs_rx_shift.sv
module sbs_rx_shift #(
   parameter int W     = 64,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             clr_cnt,
   input  logic             din,
   output logic [W-1:0]     sh_q,
   output logic [CNT_W-1:0] cnt_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (shift_en) sh_q <= {sh_q[W-2:0], din};
         if (clr_cnt)       cnt_q <= '0;
         else if (shift_en) cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sbs_tx_shift.sv
module sbs_tx_shift #(
   parameter int W     = 64,
   parameter int CNT_W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         shift_en,
   output logic         msb,
   output logic         done
);
   logic [W-1:0]     sh_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         sh_q  <= load_data;
         cnt_q <= '0;
      end else if (shift_en) begin
         sh_q  <= {sh_q[W-2:0], 1'b0};
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign msb  = sh_q[W-1];
   assign done = (cnt_q == CNT_W'(W));
endmodule

// File: rtl/sbs_block_ram.sv
module sbs_block_ram import sbs_pkg::*; #(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 8
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [BYTES*SBS_BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]         raddr,
   output logic [BYTES*SBS_BYTE_W-1:0] rdata
);
   localparam int DEPTH = 2 ** ADDR_W;

   for (genvar k = 0; k < BYTES; k++) begin : g_lane
      localparam int LSB = (BYTES - 1 - k) * SBS_BYTE_W;
      logic [SBS_BYTE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we) lane_mem[waddr] <= wdata[LSB +: SBS_BYTE_W];
         rdata[LSB +: SBS_BYTE_W] <= lane_mem[raddr];
      end
   end
endmodule

// File: rtl/serial_block_store.sv
module serial_block_store import sbs_pkg::*; #(
   parameter int              CMD_W     = 2,
   parameter int              ADDR_W    = 6,
   parameter int              BLK_BYTES = 8,
   parameter int              DUMMY_N   = 4,
   parameter logic [CMD_W-1:0] RD_CODE  = 2'b11,
   parameter logic [CMD_W-1:0] WR_CODE  = 2'b10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_stb,
   input  logic bit_in,
   input  logic out_stb,
   output logic bit_out,
   output logic data_avail,
   output logic ready,
   output logic err
);
   localparam int BLK_W  = BLK_BYTES * SBS_BYTE_W;
   localparam int CNT_W  = $clog2(BLK_W + 1);
   localparam int DCNT_W = $clog2(DUMMY_N + 1);

   if (CMD_W < 2 || CMD_W > BLK_W) begin : g_bad_cmd_w
      $error("CMD_W must lie between 2 and the block width");
   end
   if (ADDR_W < 2 || ADDR_W > BLK_W) begin : g_bad_addr_w
      $error("ADDR_W must lie between 2 and the block width");
   end
   if (DUMMY_N < 1) begin : g_bad_dummy
      $error("DUMMY_N must be at least 1");
   end
   if (RD_CODE == WR_CODE) begin : g_bad_codes
      $error("read and write codes must differ");
   end

   sbs_state_e          st_q, st_d;
   logic                rd_q, rd_d;
   logic [ADDR_W-1:0]   addr_q, addr_d;
   logic [DCNT_W-1:0]   dcnt_q, dcnt_d, dcnt_inc;
   logic                bit_out_q, bit_out_d;
   logic                err_q, err_d;

   logic                rx_shift_en, rx_clr;
   logic [BLK_W-1:0]    rx_sh;
   logic [CNT_W-1:0]    rx_cnt, cnt_inc;
   logic [CMD_W-1:0]    cmd_new;
   logic [ADDR_W-1:0]   addr_new;

   logic                tx_load, tx_shift, tx_msb, tx_done;
   logic                ram_we;
   logic [BLK_W-1:0]    ram_rdata;

   sbs_rx_shift #(.W(BLK_W), .CNT_W(CNT_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (rx_shift_en),
      .clr_cnt  (rx_clr),
      .din      (bit_in),
      .sh_q     (rx_sh),
      .cnt_q    (rx_cnt)
   );

   sbs_tx_shift #(.W(BLK_W), .CNT_W(CNT_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_load),
      .load_data (ram_rdata),
      .shift_en  (tx_shift),
      .msb       (tx_msb),
      .done      (tx_done)
   );

   sbs_block_ram #(.ADDR_W(ADDR_W), .BYTES(BLK_BYTES)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (addr_q),
      .wdata (rx_sh),
      .raddr (addr_q),
      .rdata (ram_rdata)
   );

   assign cnt_inc  = rx_cnt + 1'b1;
   assign dcnt_inc = dcnt_q + 1'b1;
   assign cmd_new  = {rx_sh[CMD_W-2:0], bit_in};
   assign addr_new = {rx_sh[ADDR_W-2:0], bit_in};

   always_comb begin
      st_d        = st_q;
      rd_d        = rd_q;
      addr_d      = addr_q;
      dcnt_d      = dcnt_q;
      bit_out_d   = bit_out_q;
      err_d       = 1'b0;
      rx_shift_en = 1'b0;
      rx_clr      = 1'b0;
      tx_load     = 1'b0;
      tx_shift    = 1'b0;
      ram_we      = 1'b0;

      if (out_stb) bit_out_d = 1'b0;

      unique case (st_q)
         ST_CMD: begin
            if (in_stb) begin
               rx_shift_en = 1'b1;
               if (cnt_inc == CNT_W'(CMD_W)) begin
                  rx_clr = 1'b1;
                  if (cmd_new == RD_CODE) begin
                     rd_d = 1'b1;
                     st_d = ST_ADDR;
                  end else if (cmd_new == WR_CODE) begin
                     rd_d = 1'b0;
                     st_d = ST_ADDR;
                  end else begin
                     err_d = 1'b1;
                  end
               end
            end
         end
         ST_ADDR: begin
            if (in_stb) begin
               rx_shift_en = 1'b1;
               if (cnt_inc == CNT_W'(ADDR_W)) begin
                  rx_clr = 1'b1;
                  addr_d = addr_new;
                  st_d   = rd_q ? ST_RSTOP : ST_WDATA;
               end
            end
         end
         ST_WDATA: begin
            if (in_stb) begin
               rx_shift_en = 1'b1;
               if (cnt_inc == CNT_W'(BLK_W)) begin
                  rx_clr = 1'b1;
                  st_d   = ST_WSTOP;
               end
            end
         end
         ST_WSTOP: begin
            if (in_stb) begin
               st_d = ST_CMD;
               if (bit_in) err_d  = 1'b1;
               else        ram_we = 1'b1;
            end
         end
         ST_RSTOP: begin
            if (in_stb) begin
               if (bit_in) begin
                  err_d = 1'b1;
                  st_d  = ST_CMD;
               end else begin
                  dcnt_d = '0;
                  st_d   = ST_DUMMY;
               end
            end
         end
         ST_DUMMY: begin
            if (out_stb) begin
               dcnt_d = dcnt_inc;
               if (dcnt_inc == DCNT_W'(DUMMY_N)) begin
                  tx_load = 1'b1;
                  st_d    = ST_TXD;
               end
            end
         end
         ST_TXD: begin
            if (out_stb) begin
               if (tx_done) begin
                  st_d = ST_CMD;
               end else begin
                  bit_out_d = tx_msb;
                  tx_shift  = 1'b1;
               end
            end
         end
         default: st_d = ST_CMD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_CMD;
         rd_q      <= 1'b0;
         addr_q    <= '0;
         dcnt_q    <= '0;
         bit_out_q <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         st_q      <= st_d;
         rd_q      <= rd_d;
         addr_q    <= addr_d;
         dcnt_q    <= dcnt_d;
         bit_out_q <= bit_out_d;
         err_q     <= err_d;
      end
   end

   assign bit_out    = bit_out_q;
   assign err        = err_q;
   assign data_avail = (st_q == ST_TXD);
   assign ready      = (st_q == ST_CMD) && (rx_cnt == '0);
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
   input logic clk,
   input logic rst_n,
   input logic in_stb,
   input logic out_stb,
   input logic bit_out,
   input logic data_avail,
   input logic ready,
   input logic err
);
   // R10: an output strobe outside the transmit phase yields 0
   a_r10_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (out_stb && !data_avail) |=> !bit_out);

   // R12: the output only moves on a strobe
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_stb |=> $stable(bit_out));

   // R8: the transmit phase is entered only through an output strobe
   a_r8_avail_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_avail) |-> $past(out_stb));

   // R8: without any strobe the transmit flag does not move
   a_r8_avail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_stb && !out_stb) |=> $stable(data_avail));

   // R13: error is a single-cycle pulse
   a_r13_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);

   // R2: an error always leaves the controller idle
   a_r2_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ready);

   // R11: leaving idle needs an input strobe
   a_r11_ready_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(in_stb));
endmodule

bind serial_block_store sbs_checker u_sbs_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_stb     (in_stb),
   .out_stb    (out_stb),
   .bit_out    (bit_out),
   .data_avail (data_avail),
   .ready      (ready),
   .err        (err)
);

// File: tb/serial_block_store_test.sv
module serial_block_store_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_stb = 1'b0;
   logic bit_in = 1'b0;
   logic out_stb = 1'b0;
   logic bit_out, data_avail, ready, err;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   serial_block_store uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_stb     (in_stb),
      .bit_in     (bit_in),
      .out_stb    (out_stb),
      .bit_out    (bit_out),
      .data_avail (data_avail),
      .ready      (ready),
      .err        (err)
   );

   function automatic logic [63:0] pat(input int a);
      return 64'h0123_4567_89AB_CDEF ^ (64'(a + 1) * 64'h9E37_79B9_7F4A_7C15);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input logic b);
      @(negedge clk); in_stb = 1'b1; bit_in = b;
      @(negedge clk); in_stb = 1'b0; bit_in = 1'b0;
   endtask

   task automatic get(output logic v);
      @(negedge clk); out_stb = 1'b1;
      @(negedge clk); out_stb = 1'b0;
      v = bit_out;
   endtask

   task automatic both(input logic b, output logic v);
      @(negedge clk); out_stb = 1'b1; in_stb = 1'b1; bit_in = b;
      @(negedge clk); out_stb = 1'b0; in_stb = 1'b0; bit_in = 1'b0;
      v = bit_out;
   endtask

   task automatic header(input logic [1:0] cmd, input logic [5:0] a);
      put(cmd[1]); put(cmd[0]);
      for (int i = 5; i >= 0; i--) put(a[i]);
   endtask

   task automatic write_block(input int a, input logic [63:0] d, input logic stop, input bit noisy_out);
      logic v;
      header(2'b10, 6'(a));
      for (int i = 63; i >= 0; i--) begin
         put(d[i]);
         if (noisy_out && i == 40) begin
            get(v);
            chk(v == 1'b0, "R10 out strobe mid-write", 64'(v), 64'd0);
         end
      end
      put(stop);
      if (stop) chk(err == 1'b1 && ready, "R5 bad write stop flags error", 64'(err), 64'd1);
      else      chk(err == 1'b0 && ready, "R5 write stop commits to idle", 64'(err), 64'd0);
   endtask

   task automatic read_block(input int a, input bit noisy_in, output logic [63:0] d);
      logic v;
      bit avail_ok;
      header(2'b11, 6'(a));
      put(1'b0);
      for (int k = 0; k < 4; k++) begin
         if (noisy_in) both(1'b1, v); else get(v);
         chk(v == 1'b0 && data_avail == (k == 3), "R7 dummy bit", {62'd0, v, data_avail}, {63'd0, k == 3});
      end
      avail_ok = 1'b1;
      for (int i = 63; i >= 0; i--) begin
         if (!data_avail) avail_ok = 1'b0;
         if (noisy_in) both(1'b1, v); else get(v);
         d[i] = v;
      end
      chk(avail_ok, "R8 data_avail during transmit", 64'(avail_ok), 64'd1);
      if (noisy_in) both(1'b1, v); else get(v);
      chk(v == 1'b0 && !data_avail && ready, "R9 strobe after last bit", {61'd0, v, data_avail, ready}, 64'd1);
   endtask

   initial begin
      logic [63:0] d;
      logic v;
      bit sweep_ok;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready && !data_avail && !bit_out && !err, "R1 reset state",
          {60'd0, ready, data_avail, bit_out, err}, 64'h8);

      // R2: illegal command codes
      put(1'b0); put(1'b0);
      chk(err && ready, "R2 code 00 error", {62'd0, err, ready}, 64'h3);
      @(negedge clk);
      chk(!err, "R13 error pulse ends", 64'(err), 64'd0);
      put(1'b0); put(1'b1);
      chk(err && ready, "R2 code 01 error", {62'd0, err, ready}, 64'h3);
      get(v);
      chk(v == 1'b0 && !data_avail, "R10 strobe while idle", 64'(v), 64'd0);

      // R3 R4: sweep every block, write then read back
      for (int a = 0; a < 64; a++) write_block(a, pat(a), 1'b0, a == 9);
      sweep_ok = 1'b1;
      for (int a = 0; a < 64; a++) begin
         read_block(a, a == 17, d);
         if (d != pat(a)) begin
            sweep_ok = 1'b0;
            chk(1'b0, "R3 R4 R8 block readback", d, pat(a));
         end
      end
      chk(sweep_ok, "R3 all blocks distinct and intact", 64'(sweep_ok), 64'd1);

      // R10: block written with an output strobe inside its data phase
      read_block(9, 1'b0, d);
      chk(d == pat(9), "R10 write with out strobe intact", d, pat(9));

      // R11: reads with input strobes held high throughout
      read_block(33, 1'b1, d);
      chk(d == pat(33), "R11 noisy read data", d, pat(33));
      chk(ready, "R11 idle after noisy read", 64'(ready), 64'd1);

      // R5: bad stop bit leaves block unchanged
      write_block(7, ~pat(7), 1'b1, 1'b0);
      @(negedge clk);
      read_block(7, 1'b0, d);
      chk(d == pat(7), "R5 block unchanged after bad stop", d, pat(7));

      // R4: overwrite with a byte-graded value, offset 0 first on the wire
      write_block(20, 64'h0011_2233_4455_6677, 1'b0, 1'b0);
      read_block(20, 1'b0, d);
      chk(d == 64'h0011_2233_4455_6677, "R4 byte order", d, 64'h0011_2233_4455_6677);

      // R6: read with a bad stop bit
      header(2'b11, 6'd3);
      put(1'b1);
      chk(err && ready, "R6 bad read stop error", {62'd0, err, ready}, 64'h3);
      get(v);
      chk(v == 1'b0 && !data_avail, "R6 no data after bad read stop", {62'd0, v, data_avail}, 64'd0);

      // R12: output holds between strobes
      write_block(40, 64'h8000_0000_0000_0001, 1'b0, 1'b0);
      header(2'b11, 6'd40);
      put(1'b0);
      for (int k = 0; k < 4; k++) get(v);
      get(v);
      chk(v == 1'b1, "R12 first data bit", 64'(v), 64'd1);
      repeat (5) @(negedge clk);
      chk(bit_out == 1'b1, "R12 output held", 64'(bit_out), 64'd1);
      for (int i = 62; i >= 0; i--) get(v);
      chk(v == 1'b1, "R8 last data bit", 64'(v), 64'd1);
      get(v);
      chk(v == 1'b0 && ready, "R9 after last bit", {62'd0, v, ready}, 64'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule